// File: doc/BRIEF.md
# Dual-Channel Absolute Peak Recorder

This block watches two signed waveform streams, one carrying line voltage and one carrying line current, and keeps for each the largest magnitude seen since the last clear. Every time the sample-valid strobe is high, the magnitude of each sample is scaled down to the register width. The stored value is replaced only when the new magnitude beats it.

Software reads the held peaks through a small address/strobe port. Each channel has two addresses. One is a plain read that leaves the register alone. The other returns the value and empties the register at the clock edge that closes the read, so a fresh measurement window starts with no lost sample. The peaks are also driven straight out, and a per-channel one-cycle flag marks every capture of a new maximum.

Top module: `abs_peak_rec`

## Requirements
- R1: While reset (active-low `rstN`) is asserted, both peak registers are zero, both new-peak flags are low, and `rdData` is zero with `rdEn` low.
- R2: A sample's magnitude is formed from the 24-bit two's-complement input and shifted right by 7 bits. The result saturates at 0xFFFF, so 0x7FFFFF and 0x800001 give 0xFFFF, the most negative code 0x800000 also gives 0xFFFF, ±0x000080 gives 1, and 0x00007F gives 0.
- R3: A peak register is loaded with the scaled magnitude only on a clock edge where `sampleValid` is high and that magnitude is strictly greater than the value held. With `sampleValid` low, samples are ignored.
- R4: A scaled magnitude equal to the held peak leaves the register unchanged and raises no flag.
- R5: Read addresses are decoded as follows: 0 is a plain voltage read, 1 a voltage read-then-clear, 2 a plain current read, 3 a current read-then-clear. `rdData` shows the addressed peak combinationally in the cycle where `rdEn` is high, and is zero when `rdEn` is low.
- R6: A plain read leaves the addressed register unchanged.
- R7: A read-then-clear returns the held value in its own cycle, and the register reads zero after that clock edge.
- R8: If a read-then-clear meets a valid sample on the same edge, the register takes the sample's scaled magnitude when that is nonzero, and zero otherwise.
- R9: A channel's new-peak flag is high for exactly the cycle after each edge that wrote a larger value into that channel's register, including a write that follows a clear.
- R10: The channels are independent: reads, clears and samples on one channel never alter the other channel's register or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Both samples are valid this cycle |
| voltSample | input | 24 | Voltage sample, two's complement |
| currSample | input | 24 | Current sample, two's complement |
| rdEn | input | 1 | Read strobe, one cycle per access |
| rdAddr | input | 2 | Read address (see R5) |
| rdData | output | 16 | Read data, valid while rdEn is high |
| voltPeak | output | 16 | Held voltage peak |
| currPeak | output | 16 | Held current peak |
| voltNewPeak | output | 1 | Voltage peak captured on last edge |
| currNewPeak | output | 1 | Current peak captured on last edge |

## Verification
The bench builds the block with its default widths: a 24-bit sample, a 16-bit peak and therefore a 7-bit scaling shift. These values keep every saturation corner reachable with literal codes. The positive and negative full-scale inputs and the most negative code land on 0xFFFF, and codes just either side of one scaled step show where truncation starts. The same widths let a read-then-clear meet a valid sample in one cycle, both with a nonzero and with a zero scaled magnitude.

// File: rtl/apk_pkg.sv
package apk_pkg;

  // number of monitored channels and their indices
  localparam int NCH  = 2;
  localparam int CH_V = 0;
  localparam int CH_I = 1;

  // strobes from control into datapath
  typedef struct packed {
    logic [NCH-1:0] sel;  // channel addressed by the current read
    logic [NCH-1:0] clr;  // channel cleared at the end of the current read
  } apkStrobe_t;

endpackage

// File: rtl/apk_ctrl.sv
module apk_ctrl
  import apk_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output apkStrobe_t        strb
);

  // address bit 0 picks read-then-clear, the bits above pick the channel
  localparam int CH_LSB = 1;

  logic [ADDR_W-CH_LSB-1:0] chIdx;
  logic                     clrReq;

  assign chIdx  = rdAddr[ADDR_W-1:CH_LSB];
  assign clrReq = rdAddr[0];

  for (genvar g = 0; g < NCH; g++) begin : gDec
    assign strb.sel[g] = rdEn && (chIdx == (ADDR_W-CH_LSB)'(g));
    assign strb.clr[g] = rdEn && clrReq && (chIdx == (ADDR_W-CH_LSB)'(g));
  end

  // R5: a read addresses at most one channel
  a_r5_one_sel: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.sel));

  // R10: a clear never reaches a channel other than the one read
  a_r10_clr_in_sel: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.clr) && ((strb.clr & ~strb.sel) == '0));

endmodule

// File: rtl/apk_datapath.sv
module apk_datapath
  import apk_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int PEAK_W   = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             sampleValid,
  input  logic [NCH-1:0][SAMPLE_W-1:0]     samples,
  input  apkStrobe_t                       strb,
  output logic [NCH-1:0][PEAK_W-1:0]       peaks,
  output logic [NCH-1:0]                   newPeak,
  output logic [PEAK_W-1:0]                rdData
);

  // keep one extra bit above the peak width to detect overflow
  localparam int SHIFT = SAMPLE_W - PEAK_W - 1;
  localparam int WIDE  = SAMPLE_W - SHIFT;
  localparam logic [SAMPLE_W-1:0] ONE = SAMPLE_W'(1);

  function automatic logic [PEAK_W-1:0] scaleAbs(input logic [SAMPLE_W-1:0] s);
    logic [SAMPLE_W-1:0] m;
    logic [WIDE-1:0]     t;
    m = s[SAMPLE_W-1] ? (~s + ONE) : s;
    t = m[SAMPLE_W-1:SHIFT];
    return t[WIDE-1] ? {PEAK_W{1'b1}} : t[PEAK_W-1:0];
  endfunction

  logic [NCH-1:0][PEAK_W-1:0] peakQ;
  logic [NCH-1:0]             flagQ;
  logic [NCH-1:0][PEAK_W-1:0] rdTerm;

  for (genvar g = 0; g < NCH; g++) begin : gCh
    logic [PEAK_W-1:0] mag;
    logic [PEAK_W-1:0] base;
    logic              win;

    assign mag  = scaleAbs(samples[g]);
    // a clear at this edge lowers the comparison floor so a new sample survives
    assign base = strb.clr[g] ? '0 : peakQ[g];
    assign win  = sampleValid && (mag > base);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        peakQ[g] <= '0;
        flagQ[g] <= 1'b0;
      end else begin
        peakQ[g] <= win ? mag : base;
        flagQ[g] <= win;
      end
    end

    assign rdTerm[g] = strb.sel[g] ? peakQ[g] : '0;

    // R3: with no sample and no clear the register holds
    a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
      (!sampleValid && !strb.clr[g]) |=> $stable(peakQ[g]));

    // R3: without a clear the register never decreases
    a_r3_monotone: assert property (@(posedge clk) disable iff (!rstN)
      !strb.clr[g] |=> (peakQ[g] >= $past(peakQ[g])));

    // R7: a clear with no sample leaves zero
    a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
      (strb.clr[g] && !sampleValid) |=> (peakQ[g] == '0));

    // R9: a flag only follows a growth or a clear-then-load
    a_r9_flag_cause: assert property (@(posedge clk) disable iff (!rstN)
      flagQ[g] |-> (peakQ[g] != '0) &&
                   ($past(strb.clr[g]) || (peakQ[g] > $past(peakQ[g]))));
  end

  always_comb begin
    rdData = '0;
    for (int k = 0; k < NCH; k++) rdData = rdData | rdTerm[k];
  end

  assign peaks   = peakQ;
  assign newPeak = flagQ;

endmodule

// File: rtl/abs_peak_rec.sv
module abs_peak_rec
  import apk_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int PEAK_W   = 16,
  parameter int ADDR_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] voltSample,
  input  logic [SAMPLE_W-1:0] currSample,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [PEAK_W-1:0]   rdData,
  output logic [PEAK_W-1:0]   voltPeak,
  output logic [PEAK_W-1:0]   currPeak,
  output logic                voltNewPeak,
  output logic                currNewPeak
);

  apkStrobe_t                 strb;
  logic [NCH-1:0][SAMPLE_W-1:0] samples;
  logic [NCH-1:0][PEAK_W-1:0]   peaks;
  logic [NCH-1:0]               newPeak;

  assign samples[CH_V] = voltSample;
  assign samples[CH_I] = currSample;

  apk_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .rdEn   (rdEn),
    .rdAddr (rdAddr),
    .strb   (strb)
  );

  apk_datapath #(.SAMPLE_W(SAMPLE_W), .PEAK_W(PEAK_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .samples     (samples),
    .strb        (strb),
    .peaks       (peaks),
    .newPeak     (newPeak),
    .rdData      (rdData)
  );

  assign voltPeak    = peaks[CH_V];
  assign currPeak    = peaks[CH_I];
  assign voltNewPeak = newPeak[CH_V];
  assign currNewPeak = newPeak[CH_I];

endmodule

// File: tb/abs_peak_rec_test.sv
module abs_peak_rec_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [23:0] voltSample = '0;
  logic [23:0] currSample = '0;
  logic        rdEn = 1'b0;
  logic [1:0]  rdAddr = '0;
  logic [15:0] rdData, voltPeak, currPeak;
  logic        voltNewPeak, currNewPeak;

  int nChk = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  abs_peak_rec uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .voltSample(voltSample), .currSample(currSample),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .voltPeak(voltPeak), .currPeak(currPeak),
    .voltNewPeak(voltNewPeak), .currNewPeak(currNewPeak)
  );

  typedef struct packed {
    logic        vld;
    logic [23:0] vs;
    logic [23:0] is;
    logic        rd;
    logic [1:0]  addr;
    logic [15:0] expRd;
    logic [15:0] expV;
    logic [15:0] expI;
    logic        expFv;
    logic        expFi;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    // R3 R2: first capture, negative current
    '{1'b1, 24'h001000, 24'hFFFC00, 1'b0, 2'd0, 16'h0000, 16'h0020, 16'h0008, 1'b1, 1'b1},
    // R3 R10: smaller voltage ignored, larger current taken
    '{1'b1, 24'h000F80, 24'h000500, 1'b0, 2'd0, 16'h0000, 16'h0020, 16'h000A, 1'b0, 1'b1},
    // R4: equal magnitudes, no update or flag
    '{1'b1, 24'hFFF000, 24'h000500, 1'b0, 2'd0, 16'h0000, 16'h0020, 16'h000A, 1'b0, 1'b0},
    // R3: sampleValid low, full scale ignored
    '{1'b0, 24'h7FFFFF, 24'h7FFFFF, 1'b0, 2'd0, 16'h0000, 16'h0020, 16'h000A, 1'b0, 1'b0},
    // R5 R6: plain voltage read
    '{1'b0, 24'h000000, 24'h000000, 1'b1, 2'd0, 16'h0020, 16'h0020, 16'h000A, 1'b0, 1'b0},
    // R5 R6: plain current read
    '{1'b0, 24'h000000, 24'h000000, 1'b1, 2'd2, 16'h000A, 16'h0020, 16'h000A, 1'b0, 1'b0},
    // R7 R10: voltage read-then-clear
    '{1'b0, 24'h000000, 24'h000000, 1'b1, 2'd1, 16'h0020, 16'h0000, 16'h000A, 1'b0, 1'b0},
    // R2: most negative current saturates
    '{1'b1, 24'h000100, 24'h800000, 1'b0, 2'd0, 16'h0000, 16'h0002, 16'hFFFF, 1'b1, 1'b1},
    // R8 R9: current clear with valid nonzero sample; voltage full scale
    '{1'b1, 24'h7FFFFF, 24'h000200, 1'b1, 2'd3, 16'hFFFF, 16'hFFFF, 16'h0004, 1'b1, 1'b1},
    // R8 R2: current clear with a sample that scales to zero
    '{1'b1, 24'h000000, 24'h00007F, 1'b1, 2'd3, 16'h0004, 16'hFFFF, 16'h0000, 1'b0, 1'b0},
    // R2 R4: -0x7FFFFF equals held full scale; 0x80 scales to 1
    '{1'b1, 24'h800001, 24'h000080, 1'b0, 2'd0, 16'h0000, 16'hFFFF, 16'h0001, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 voltPeak", voltPeak, 0);
    check("R1 currPeak", currPeak, 0);
    check("R1 flags", {voltNewPeak, currNewPeak}, 0);
    check("R1 rdData", rdData, 0);
    rstN = 1'b1;

    for (int n = 0; n < NV; n++) begin
      @(negedge clk);
      sampleValid = TBL[n].vld;
      voltSample  = TBL[n].vs;
      currSample  = TBL[n].is;
      rdEn        = TBL[n].rd;
      rdAddr      = TBL[n].addr;
      #1;
      check($sformatf("R5 rdData vec %0d", n), rdData, TBL[n].expRd);
      @(posedge clk);
      #1;
      check($sformatf("R3 voltPeak vec %0d", n), voltPeak, TBL[n].expV);
      check($sformatf("R3 currPeak vec %0d", n), currPeak, TBL[n].expI);
      check($sformatf("R9 voltNewPeak vec %0d", n), voltNewPeak, TBL[n].expFv);
      check($sformatf("R9 currNewPeak vec %0d", n), currNewPeak, TBL[n].expFi);
    end

    // R9: flag lasts one cycle when nothing new arrives
    @(negedge clk);
    sampleValid = 1'b0; rdEn = 1'b0;
    @(posedge clk); #1;
    check("R9 flag drop", {voltNewPeak, currNewPeak}, 0);
    check("R5 rdData idle", rdData, 0);

    // R7: clear of voltage reads full scale, then zero
    @(negedge clk);
    rdEn = 1'b1; rdAddr = 2'd1;
    #1 check("R7 clear returns value", rdData, 16'hFFFF);
    @(posedge clk); #1;
    check("R7 cleared", voltPeak, 0);
    check("R10 current untouched", currPeak, 16'h0001);
    @(negedge clk);
    rdEn = 1'b0;

    // R1: reset mid-run clears everything
    @(negedge clk);
    sampleValid = 1'b1; currSample = 24'h7FFFFF; voltSample = 24'h7FFFFF;
    @(posedge clk); #1;
    check("R2 full scale volt", voltPeak, 16'hFFFF);
    @(negedge clk);
    sampleValid = 1'b0;
    rstN = 1'b0;
    #1;
    check("R1 async volt", voltPeak, 0);
    check("R1 async curr", currPeak, 0);
    check("R1 async flags", {voltNewPeak, currNewPeak}, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    summary();
  end

endmodule